// File: doc/BRIEF.md
# SPI Mode-3 Master with Select Lead Delay

This block is an SPI master for register access to a peripheral. It runs in mode 3: the serial clock idles high, MOSI changes on falling edges and MISO is sampled on rising edges. The block produces the serial clock by dividing the system clock. A `div` input gives the length of one half-period in system clock cycles.

A transfer starts when `start` is seen while `ready` is high. At that edge the block latches the byte count, the transmit bytes, the divider and the requested lead time. It then drives the active-low select low. It waits a lead delay before the first falling edge. The lead delay is the requested number of system cycles, rounded up to whole half-periods and clamped to one or two half-periods.

All bytes go out back to back, MSB first, with no gap in the serial clock. The byte received during each byte slot is presented with a one-cycle valid strobe. When the last bit is done, the serial clock stays high for one half-period before select is released. Select then stays high for one more half-period before `ready` returns.

Top module: `spi3_master`

## Requirements
- R1: While reset is applied and afterwards until the first start, `sel_n`=1, `sclk`=1, `mosi`=1, `ready`=1 and `rx_valid`=0.
- R2: The half-period H of `sclk` is `div` system cycles, with `div`=0 treated as 1. Once the lead delay ends, `sclk` alternates low and high every H cycles, starting low.
- R3: With accept edge t0, `sel_n` goes low after t0. The first falling `sclk` edge comes L·H cycles after t0, where L = ceil(`lead_cyc`/H) clamped to the range 1..2.
- R4: `mosi` changes only on falling `sclk` edges and stays 1 before the first falling edge. The bit stream is byte 0 (`tx_bytes[7:0]`), then byte 1 (`tx_bytes[15:8]`), and so on, each byte MSB first.
- R5: `miso` is sampled on each rising `sclk` edge. After every 8th rising edge, `rx_valid` is high for one cycle and `rx_byte` holds the eight sampled bits, the first one in bit 7.
- R6: A `nbytes` value of n gives n+1 bytes. `sel_n` stays low and `sclk` keeps running without a pause across byte boundaries.
- R7: After the last rising edge, `sclk` stays high for H cycles. Then `sel_n` returns high, and `mosi` returns to 1 at the same edge.
- R8: `ready` is low from the accept edge until H cycles after `sel_n` rises. `start`, and changes to `div`, `lead_cyc`, `nbytes` or `tx_bytes`, have no effect on a transfer in progress.
- R9: `sclk` is high whenever `sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, accepted when `ready` is high |
| ready | output | 1 | High when a new transfer can be accepted |
| nbytes | input | $clog2(MAXB) | Byte count minus one |
| tx_bytes | input | MAXB*8 | Transmit bytes, byte 0 in the low bits |
| div | input | DIV_W | Half-period in system cycles (0 treated as 1) |
| lead_cyc | input | DIV_W | Requested select-to-first-edge delay in system cycles |
| rx_byte | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |
| sclk | output | 1 | Serial clock, idles high |
| sel_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench targets these corner cases:
- `div`=0 and `div`=1, where a half-period is a single system cycle. A divider with an off-by-one error would stretch or collapse every clock phase.
- Lead requests that land exactly on a half-period boundary, just past one, and far beyond the clamp. Wrong rounding would move the first falling edge by a half-period, and a missing clamp would stall select for hundreds of cycles.
- Multi-byte frames with different data in every byte. A pause or a lost bit at a byte boundary would misalign every later bit of `mosi` and `rx_byte`.
- A start pulse, together with new settings, injected in the middle of a transfer. A block that re-arms or re-latches on it would corrupt the frame or lose the tail and gap timing.

// File: rtl/spi3_master.sv
module spi3_master #(
  parameter int DIV_W = 8,
  parameter int MAXB  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     ready,
  input  logic [$clog2(MAXB)-1:0]  nbytes,
  input  logic [MAXB*8-1:0]        tx_bytes,
  input  logic [DIV_W-1:0]         div,
  input  logic [DIV_W-1:0]         lead_cyc,
  output logic [7:0]               rx_byte,
  output logic                     rx_valid,
  output logic                     sclk,
  output logic                     sel_n,
  output logic                     mosi,
  input  logic                     miso
);
  localparam int TXW   = MAXB * 8;
  localparam int BIT_W = $clog2(TXW + 1);

  typedef enum logic [2:0] {IDLE, LEAD, SHIFT, TAIL, GAP} st_t;

  st_t              st;
  logic [DIV_W-1:0] half, cnt;
  logic             lead2;
  logic [TXW-1:0]   sh, tx_ord;
  logic [7:0]       rxs;
  logic [BIT_W-1:0] left;
  logic [2:0]       bpos;

  wire              tick    = (cnt == '0);
  wire [DIV_W-1:0]  div_eff = (div == '0) ? DIV_W'(1) : div;

  always_comb
    for (int i = 0; i < MAXB; i++)
      tx_ord[TXW-1-8*i -: 8] = tx_bytes[8*i +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      ready    <= 1'b1;
      sel_n    <= 1'b1;
      sclk     <= 1'b1;
      mosi     <= 1'b1;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rxs      <= '0;
      cnt      <= '0;
      half     <= DIV_W'(1);
      lead2    <= 1'b0;
      sh       <= '0;
      left     <= '0;
      bpos     <= '0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          ready <= 1'b0;
          sel_n <= 1'b0;
          half  <= div_eff;
          cnt   <= div_eff - 1'b1;
          lead2 <= (lead_cyc > div_eff);
          sh    <= tx_ord;
          left  <= BIT_W'((int'(nbytes) + 1) * 8);
          bpos  <= '0;
          st    <= LEAD;
        end
        LEAD: if (tick) begin
          cnt <= half - 1'b1;
          if (lead2) lead2 <= 1'b0;
          else begin
            sclk <= 1'b0;
            mosi <= sh[TXW-1];
            sh   <= sh << 1;
            st   <= SHIFT;
          end
        end else cnt <= cnt - 1'b1;
        SHIFT: if (tick) begin
          cnt <= half - 1'b1;
          if (!sclk) begin
            sclk <= 1'b1;
            rxs  <= {rxs[6:0], miso};
            bpos <= bpos + 3'd1;
            left <= left - 1'b1;
            if (bpos == 3'd7) begin
              rx_valid <= 1'b1;
              rx_byte  <= {rxs[6:0], miso};
            end
            if (left == BIT_W'(1)) st <= TAIL;
          end else begin
            sclk <= 1'b0;
            mosi <= sh[TXW-1];
            sh   <= sh << 1;
          end
        end else cnt <= cnt - 1'b1;
        TAIL: if (tick) begin
          cnt   <= half - 1'b1;
          sel_n <= 1'b1;
          mosi  <= 1'b1;
          st    <= GAP;
        end else cnt <= cnt - 1'b1;
        GAP: if (tick) begin
          ready <= 1'b1;
          st    <= IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi3_master_chk.sv
module spi3_master_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic ready,
  input logic rx_valid,
  input logic sclk,
  input logic sel_n,
  input logic mosi
);
  // R9
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> sclk);

  // R7
  release_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_n) |-> $past(sclk));

  // R8
  busy_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> !ready);

  // R8
  select_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n) |-> $past(start && ready));

  // R4
  mosi_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  // R5
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  valid_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sel_n);
endmodule

bind spi3_master spi3_master_chk chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
  .rx_valid(rx_valid), .sclk(sclk), .sel_n(sel_n), .mosi(mosi)
);

// File: tb/spi3_master_test.sv
module spi3_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  nbytes = '0;
  logic [31:0] tx_bytes = '0;
  logic [7:0]  div = 8'd1;
  logic [7:0]  lead_cyc = '0;
  logic        miso = 1'b0;
  logic        ready, rx_valid, sclk, sel_n, mosi;
  logic [7:0]  rx_byte;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] sl_pat = '0;
  int          sl_idx = 0;

  always #10 clk = ~clk;

  spi3_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .nbytes(nbytes),
    .tx_bytes(tx_bytes), .div(div), .lead_cyc(lead_cyc), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .sclk(sclk), .sel_n(sel_n), .mosi(mosi), .miso(miso)
  );

  always @(negedge sel_n) sl_idx = 0;
  always @(negedge sclk) if (!sel_n) begin
    miso <= sl_pat[31 - (sl_idx % 32)];
    sl_idx = sl_idx + 1;
  end

  task automatic chk(input bit ok, input string req, input string nm,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    chk(sel_n == 1'b1, req, "sel_n", sel_n, 1);
    chk(sclk == 1'b1, req, "sclk", sclk, 1);
    chk(mosi == 1'b1, req, "mosi", mosi, 1);
    chk(ready == 1'b1, req, "ready", ready, 1);
    chk(rx_valid == 1'b0, req, "rx_valid", rx_valid, 0);
  endtask

  task automatic run(input int dv, input int ld, input int nb,
                     input logic [31:0] tx, input logic [31:0] sp, input int poke);
    int h, l, total, q, b, j;
    bit e_sel, e_clk, e_mosi, e_rdy, e_val;
    h = (dv == 0) ? 1 : dv;
    l = (ld + h - 1) / h;
    if (l < 1) l = 1;
    if (l > 2) l = 2;
    total = (l + 16 * nb + 1) * h;
    for (int w = 0; w < 1000 && !ready; w++) @(negedge clk);
    @(negedge clk);
    div = 8'(dv); lead_cyc = 8'(ld); nbytes = 2'(nb - 1);
    tx_bytes = tx; sl_pat = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int d = 0; d <= total + 1; d++) begin
      e_rdy = (d >= total);
      e_sel = (d >= (l + 16 * nb) * h);
      e_clk = 1'b1; e_mosi = 1'b1; e_val = 1'b0;
      if (d >= l * h && !e_sel) begin
        q = (d - l * h) / h;
        e_clk = q[0];
        b = q / 2;
        e_mosi = tx[8 * (b / 8) + 7 - (b % 8)];
        if (q % 16 == 15 && (d - l * h) % h == 0) e_val = 1'b1;
      end
      // R2 clock phases, R9 clock high while deselected
      chk(sclk == e_clk, e_sel ? "R9" : "R2", "sclk", sclk, e_clk);
      // R3 lead, R6 continuous select, R7 release timing
      chk(sel_n == e_sel, "R3/R6/R7", "sel_n", sel_n, e_sel);
      // R4 data order and change edge
      chk(mosi == e_mosi, "R4", "mosi", mosi, e_mosi);
      // R8 busy window, start ignored
      chk(ready == e_rdy, "R8", "ready", ready, e_rdy);
      chk(rx_valid == e_val, "R5", "rx_valid", rx_valid, e_val);
      if (e_val) begin
        j = (d - l * h) / (16 * h);
        chk(rx_byte == sp[31 - 8 * j -: 8], "R5/R6", "rx_byte", rx_byte, sp[31 - 8 * j -: 8]);
      end
      if (d == poke) begin
        start = 1'b1; div = 8'd7; lead_cyc = 8'd0; nbytes = 2'd0; tx_bytes = ~tx;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    idle_check("R1");
    run(1, 0, 1, 32'h0000_00A5, 32'h3C00_0000, -1);
    run(2, 3, 2, 32'h0000_81F0, 32'hC3E1_0000, -1);
    run(4, 4, 4, 32'h1234_5678, 32'h9ABC_DEF0, 9);
    run(0, 200, 3, 32'h00C0_FFEE, 32'h5AA5_7E00, 20);
    run(3, 5, 1, 32'h0000_0001, 32'h8000_0000, -1);
    run(3, 3, 2, 32'h0000_7F80, 32'h01FE_0000, 30);
    @(negedge clk);
    idle_check("R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule